// File: doc/BRIEF.md
# PC Card Byte-Lane Steering Memory

This block is the card side of a 16-bit PC Card memory slot. It holds a small common-memory array and a separate attribute-memory array. It decodes the host's two active-low lane enables, the byte-select address bit, the read and write strobes and the attribute-space select. From these it routes bytes between the two data lanes and the arrays. It does not use tri-state pins. Each lane has its own data-valid enable, and the pad ring builds the bidirectional bus from these.

An 8-bit host can reach every byte over the low lane alone, because the byte-select bit chooses between the even and odd byte. A 16-bit host moves whole words, or it can move only the odd byte over the high lane. Attribute space stores even bytes only.

Writes to common memory are held off in two cases. A write-protect input blocks all of them. A per-bank programming-voltage-good input blocks writes to its own bank. The card never asks the host to wait.

Top module: `pccard_lane_mem`

## Requirements
- R1: When both `ce_lo_n` and `ce_hi_n` are high, `dout_lo_en` and `dout_hi_en` are low, and a write strobe changes no stored byte.
- R2: When `ce_lo_n` is low and `ce_hi_n` is high, the access is a byte access on `dout[7:0]` / `din[7:0]`. With `a0` = 0 it reaches the even byte of the word, and with `a0` = 1 it reaches the odd byte. `dout_hi_en` stays low.
- R3: When both enables are low, the access is a word access: the odd byte is on bits 15:8 and the even byte on bits 7:0, whatever `a0` is.
- R4: When `ce_hi_n` is low and `ce_lo_n` is high, only the odd byte is accessed, on bits 15:8. `dout_lo_en` stays low.
- R5: A lane enable is high only while `oe_n` is low, `we_n` is high and that lane is selected. A write needs `oe_n` high at its commit point.
- R6: When `reg_n` is low, the access goes to attribute memory, which stores even bytes only. An odd-byte attribute read returns 8'hFF, and an odd-byte attribute write is discarded. In an attribute word read, the even byte is on bits 7:0 and 8'hFF is on bits 15:8.
- R7: The word address `haddr` wraps modulo the array depth. Common memory has 2**CMEM_AW words and attribute memory has 2**AMEM_AW bytes.
- R8: While `wp` is high, no common-memory byte changes. Attribute writes still take effect.
- R9: A common-memory write updates the even bank only if `vpp_even_ok` is high, and the odd bank only if `vpp_odd_ok` is high. Each bank is checked on its own.
- R10: `wait_n` is always high.
- R11: A write commits on the second rising clock edge after the synchronised `we_n` rises. It uses the address, lane selects and data present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst_n | input | 1 | Active-low reset of the strobe synchroniser |
| ce_lo_n | input | 1 | Low-lane / even-byte enable, active low |
| ce_hi_n | input | 1 | High-lane / odd-byte enable, active low |
| a0 | input | 1 | Byte select for low-lane byte accesses |
| haddr | input | HADDR_W | Host word address (address bits above a0) |
| oe_n | input | 1 | Read strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| reg_n | input | 1 | Attribute-space select, active low |
| wp | input | 1 | Write protect for common memory |
| vpp_even_ok | input | 1 | Programming voltage good, even bank |
| vpp_odd_ok | input | 1 | Programming voltage good, odd bank |
| din | input | 16 | Write data from host |
| dout | output | 16 | Read data to host |
| dout_lo_en | output | 1 | Drive enable for bits 7:0 |
| dout_hi_en | output | 1 | Drive enable for bits 15:8 |
| wait_n | output | 1 | Wait request, never asserted |

## Verification
The bench builds the block with HADDR_W=6, CMEM_AW=4 and AMEM_AW=3, which gives 16 common words and 8 attribute bytes. With these values, a host address above the array depth is still inside the address bus, so the wrap can be tested for both arrays with a single extra address bit. The small arrays also make it cheap to write one word and then read it back in every lane mode.

// File: rtl/pccard_lane_mem.sv
module pccard_lane_mem #(
  parameter int HADDR_W = 6,
  parameter int CMEM_AW = 4,
  parameter int AMEM_AW = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ce_lo_n,
  input  logic               ce_hi_n,
  input  logic               a0,
  input  logic [HADDR_W-1:0] haddr,
  input  logic               oe_n,
  input  logic               we_n,
  input  logic               reg_n,
  input  logic               wp,
  input  logic               vpp_even_ok,
  input  logic               vpp_odd_ok,
  input  logic [15:0]        din,
  output logic [15:0]        dout,
  output logic               dout_lo_en,
  output logic               dout_hi_en,
  output logic               wait_n
);
  localparam int CDEPTH = 1 << CMEM_AW;
  localparam int ADEPTH = 1 << AMEM_AW;

  logic [7:0] cm_even [CDEPTH];
  logic [7:0] cm_odd  [CDEPTH];
  logic [7:0] am      [ADEPTH];
  logic [1:0] we_q;

  wire [CMEM_AW-1:0] caddr = haddr[CMEM_AW-1:0];
  wire [AMEM_AW-1:0] aaddr = haddr[AMEM_AW-1:0];
  wire unused_addr = ^haddr;

  wire sel_lo   = !ce_lo_n;
  wire sel_hi   = !ce_hi_n;
  wire word     = sel_lo && sel_hi;
  wire hit_even = sel_lo && (word || !a0);
  wire hit_odd  = sel_hi || (sel_lo && a0);
  wire [7:0] odd_wd = sel_hi ? din[15:8] : din[7:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) we_q <= 2'b11;
    else        we_q <= {we_q[0], we_n};

  wire commit = we_q[0] && !we_q[1] && oe_n;

  always_ff @(posedge clk) begin
    if (commit) begin
      if (reg_n) begin
        if (hit_even && !wp && vpp_even_ok) cm_even[caddr] <= din[7:0];
        if (hit_odd  && !wp && vpp_odd_ok)  cm_odd[caddr]  <= odd_wd;
      end else if (hit_even) begin
        am[aaddr] <= din[7:0];
      end
    end
  end

  wire rd = !oe_n && we_n;
  wire [7:0] lo_byte = !reg_n ? ((word || !a0) ? am[aaddr] : 8'hFF)
                              : ((!word && a0) ? cm_odd[caddr] : cm_even[caddr]);
  wire [7:0] hi_byte = reg_n ? cm_odd[caddr] : 8'hFF;

  assign dout       = {hi_byte, lo_byte};
  assign dout_lo_en = rd && sel_lo;
  assign dout_hi_en = rd && sel_hi;
  assign wait_n     = 1'b1;
endmodule

// File: rtl/pccard_lane_mem_chk.sv
module pccard_lane_mem_chk #(
  parameter int HADDR_W = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ce_lo_n,
  input logic               ce_hi_n,
  input logic               a0,
  input logic [HADDR_W-1:0] haddr,
  input logic               oe_n,
  input logic               we_n,
  input logic               reg_n,
  input logic               wp,
  input logic [15:0]        dout,
  input logic               dout_lo_en,
  input logic               dout_hi_en
);
  AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_lo_n && ce_hi_n) |-> (!dout_lo_en && !dout_hi_en)); // R1
  AST_BYTE_HI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_lo_n && ce_hi_n) |-> !dout_hi_en); // R2
  AST_ODDONLY_LO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_lo_n && !ce_hi_n) |-> !dout_lo_en); // R4
  AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n || oe_n) |-> (!dout_lo_en && !dout_hi_en)); // R5
  AST_ATTR_ODD_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_n && dout_hi_en) |-> (dout[15:8] == 8'hFF)); // R6
  AST_WP_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (wp && $past(wp) && reg_n && $past(reg_n) && $stable(haddr) && $stable(a0)
     && $stable(ce_lo_n) && $stable(ce_hi_n) && dout_lo_en && $past(dout_lo_en))
    |-> $stable(dout[7:0])); // R8
endmodule

bind pccard_lane_mem pccard_lane_mem_chk #(.HADDR_W(HADDR_W)) u_chk (.*);

// File: tb/sim_pccard_lane_mem.sv
module sim_pccard_lane_mem;
  localparam int CLK_PER = 10;
  localparam int HW = 6;

  logic clk = 0, rst_n = 0;
  logic ce_lo_n = 1, ce_hi_n = 1, a0 = 0, oe_n = 1, we_n = 1, reg_n = 1;
  logic wp = 0, vpp_even_ok = 1, vpp_odd_ok = 1;
  logic [HW-1:0] haddr = '0;
  logic [15:0] din = '0, dout;
  logic dout_lo_en, dout_hi_en, wait_n;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PER/2) clk = ~clk;

  pccard_lane_mem #(.HADDR_W(HW), .CMEM_AW(4), .AMEM_AW(3)) u0 (.*);

  task automatic chk(string req, logic [17:0] act, logic [17:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic rg, logic c1, logic c2, logic b0, int adr, logic [15:0] d,
                    logic keep_oe = 1'b0);
    @(negedge clk);
    reg_n = rg; ce_lo_n = c1; ce_hi_n = c2; a0 = b0; haddr = HW'(adr); din = d;
    oe_n = keep_oe ? 1'b0 : 1'b1; we_n = 0;
    repeat (2) @(negedge clk);
    we_n = 1;
    repeat (3) @(negedge clk);
    ce_lo_n = 1; ce_hi_n = 1; oe_n = 1; reg_n = 1;
  endtask

  task automatic rd(logic rg, logic c1, logic c2, logic b0, int adr,
                    output logic [17:0] res);
    @(negedge clk);
    reg_n = rg; ce_lo_n = c1; ce_hi_n = c2; a0 = b0; haddr = HW'(adr); oe_n = 0;
    #1 res = {dout_hi_en, dout_lo_en, dout};
    @(negedge clk);
    oe_n = 1; ce_lo_n = 1; ce_hi_n = 1; reg_n = 1;
  endtask

  task automatic t_reset;
    logic [17:0] r;
    #1 chk("R1 reset idle enables", {16'h0, dout_hi_en, dout_lo_en}, 18'h0);
    chk("R10 wait high", {17'h0, wait_n}, 18'h1);
    rd(1, 1, 1, 0, 0, r);
    chk("R1 standby read", {16'h0, r[17:16]}, 18'h0);
  endtask

  task automatic t_lanes;
    logic [17:0] r;
    wr(1, 0, 0, 0, 5, 16'hA55A);
    rd(1, 0, 0, 1, 5, r);
    chk("R3 word read a0 ignored", r, {2'b11, 16'hA55A});
    rd(1, 0, 1, 0, 5, r);
    chk("R2 byte even", {r[17:16], r[7:0]}, {2'b01, 8'h5A});
    rd(1, 0, 1, 1, 5, r);
    chk("R2 byte odd on low lane", {r[17:16], r[7:0]}, {2'b01, 8'hA5});
    rd(1, 1, 0, 0, 5, r);
    chk("R4 odd-only read", {r[17:16], r[15:8]}, {2'b10, 8'hA5});
    wr(1, 0, 1, 1, 6, 16'h003C);
    wr(1, 0, 1, 0, 6, 16'h00C3);
    rd(1, 0, 0, 0, 6, r);
    chk("R2 byte writes assemble word", r, {2'b11, 16'h3CC3});
    wr(1, 0, 0, 0, 7, 16'h1122);
    wr(1, 1, 0, 0, 7, 16'h99EE);
    rd(1, 0, 0, 0, 7, r);
    chk("R4 odd-only write keeps even", r, {2'b11, 16'h9922});
  endtask

  task automatic t_gating;
    logic [17:0] r;
    wr(1, 1, 1, 0, 5, 16'hFFFF);
    rd(1, 0, 0, 0, 5, r);
    chk("R1 standby write ignored", r, {2'b11, 16'hA55A});
    @(negedge clk);
    ce_lo_n = 0; ce_hi_n = 0; oe_n = 0; we_n = 0;
    #1 chk("R5 no drive while WE low", {16'h0, dout_hi_en, dout_lo_en}, 18'h0);
    @(negedge clk);
    we_n = 1; oe_n = 1; ce_lo_n = 1; ce_hi_n = 1;
    repeat (3) @(negedge clk);
    wr(1, 0, 0, 0, 5, 16'h0000, 1'b1);
    rd(1, 0, 0, 0, 5, r);
    chk("R5 write with OE low ignored", r, {2'b11, 16'hA55A});
  endtask

  task automatic t_attr;
    logic [17:0] r;
    wr(0, 0, 0, 0, 2, 16'h4455);
    rd(0, 0, 0, 0, 2, r);
    chk("R6 attr word read", r, {2'b11, 16'hFF55});
    rd(0, 0, 1, 1, 2, r);
    chk("R6 attr odd byte read FF", {r[17:16], r[7:0]}, {2'b01, 8'hFF});
    wr(0, 0, 1, 1, 2, 16'h0066);
    wr(0, 1, 0, 0, 2, 16'h7700);
    rd(0, 0, 1, 0, 2, r);
    chk("R6 attr odd write discarded", {r[17:16], r[7:0]}, {2'b01, 8'h55});
  endtask

  task automatic t_wrap;
    logic [17:0] r;
    wr(1, 0, 0, 0, 3 + 16, 16'hBEEF);
    rd(1, 0, 0, 0, 3, r);
    chk("R7 common wrap", r, {2'b11, 16'hBEEF});
    wr(0, 0, 1, 0, 10, 16'h0011);
    rd(0, 0, 1, 0, 2, r);
    chk("R7 attr wrap", {r[17:16], r[7:0]}, {2'b01, 8'h11});
  endtask

  task automatic t_protect;
    logic [17:0] r;
    wp = 1;
    wr(1, 0, 0, 0, 5, 16'h0000);
    rd(1, 0, 0, 0, 5, r);
    chk("R8 wp blocks common", r, {2'b11, 16'hA55A});
    wr(0, 0, 1, 0, 4, 16'h00C7);
    rd(0, 0, 1, 0, 4, r);
    chk("R8 wp allows attr", {r[17:16], r[7:0]}, {2'b01, 8'hC7});
    wp = 0;
    vpp_even_ok = 0;
    wr(1, 0, 0, 0, 5, 16'h0000);
    rd(1, 0, 0, 0, 5, r);
    chk("R9 even bank needs vpp", r, {2'b11, 16'h005A});
    vpp_even_ok = 1; vpp_odd_ok = 0;
    wr(1, 0, 0, 0, 5, 16'h1234);
    rd(1, 0, 0, 0, 5, r);
    chk("R9 odd bank needs vpp", r, {2'b11, 16'h0034});
    vpp_odd_ok = 1;
  endtask

  task automatic t_commit;
    logic [17:0] r;
    @(negedge clk);
    ce_lo_n = 0; ce_hi_n = 0; haddr = 9; din = 16'h1111; we_n = 0;
    repeat (2) @(negedge clk);
    we_n = 1;
    @(negedge clk);
    din = 16'h2222;
    repeat (3) @(negedge clk);
    ce_lo_n = 1; ce_hi_n = 1;
    rd(1, 0, 0, 0, 9, r);
    chk("R11 data taken at second edge", r, {2'b11, 16'h2222});
    chk("R10 wait still high", {17'h0, wait_n}, 18'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_lanes();
    t_gating();
    t_attr();
    t_wrap();
    t_protect();
    t_commit();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PER * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule